// File: doc/BRIEF.md
# Register-Mapped Rounding Integer Divider

This block is a division coprocessor on a byte-wide register bus. Software loads a 64-bit dividend into operand register C and a 64-bit divisor into operand register A. It then writes the control byte with the start bit set. The hardware runs a shift-subtract loop that produces one quotient bit per clock. When the loop ends, the quotient overwrites A, the remainder goes into B, and the start bit drops back to zero. Software polls that bit to learn when the result is ready.

The control byte selects unsigned or two's-complement arithmetic. It also selects whether the quotient is truncated or rounded to the nearest integer. The operands are turned into magnitudes before the loop. After the loop, the signs are put back and any rounding is applied. A zero divisor is caught before the loop starts and produces a fixed result.

Top module: `mduDivTop`

## Requirements
- R1: Register map: addresses 0..7 are the bytes of A, least significant byte at 0. Addresses 8..15 are B in the same order, 16..23 are C in the same order, and 24 is the control byte. A read returns the addressed byte combinationally.
- R2: Writing the control byte with bit 7 set while idle starts a division. Bit 7 reads 1 for exactly WIDTH+2 clock cycles (66 by default), counted from the write edge, and then reads 0.
- R3: With bit 3 clear (unsigned), A receives floor(C/A) and B receives C mod A.
- R4: With bit 3 set (signed, two's complement), the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R5: With bit 6 set, the quotient is rounded to the nearest integer, with ties rounded away from zero. B still receives the truncated-division remainder.
- R6: A zero divisor leaves A as all ones and B equal to C, in any mode. Bit 7 is then cleared after a single busy cycle.
- R7: Bus writes to A, B, C or the control byte have no effect while bit 7 reads 1.
- R8: The control byte reads back as bit 7 = busy, bit 6 = round mode and bit 3 = signed mode. Bits 5..4 and 2..0 always read 0. Any idle write updates the mode bits, including one that does not start a division.
- R9: A division leaves C unchanged.
- R10: After reset, every operand byte and the control byte read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte for `addr` |

## Verification
The bench goes after the sign corners:
- A negative dividend with a positive divisor and the reverse case, where a design that applied the quotient sign to the remainder would return the wrong sign in B.
- The most negative dividend divided by minus one, where a broken magnitude path loses the top bit.
- The same bit pattern divided as unsigned, which exposes a design that ignores the signed bit.

Rounding is tested on exact half-way remainders in both signs, so that a "greater than" compare in place of "greater or equal" fails. A design that rounded the remainder as well as the quotient would also fail these cases. Busy-time writes, a zero divisor, the exact busy length and reserved control bits catch, in turn: a register file left open during a run, a loop that divides by zero, an off-by-one iteration count, and stray stored bits.

// File: rtl/mduDivPkg.sv
package mduDivPkg;
  typedef struct packed {
    logic load;     // capture magnitudes and signs
    logic step;     // one shift-subtract iteration
    logic finish;   // sign fix, rounding, write back
    logic divZero;  // zero divisor write back
  } strobeT;

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_ITER, S_FIX} stateT;
endpackage

// File: rtl/mduDivCtrl.sv
module mduDivCtrl
  import mduDivPkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              divIsZero,
  output strobeT            strobe,
  output logic              busy,
  output logic              roundMode,
  output logic              signedMode,
  output logic [7:0]        ctrlByte
);
  localparam int BYTES = WIDTH / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3 * BYTES);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(WIDTH - 1);

  stateT state;
  logic [CNT_W-1:0] iterCnt;
  logic unusedBits;

  assign unusedBits = ^{wrData[5:4], wrData[2:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      iterCnt    <= '0;
      roundMode  <= 1'b0;
      signedMode <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wrEn && addr == CTRL_ADDR) begin
          roundMode  <= wrData[6];
          signedMode <= wrData[3];
          if (wrData[7]) state <= S_PREP;
        end
        S_PREP: begin
          iterCnt <= '0;
          state   <= divIsZero ? S_IDLE : S_ITER;
        end
        S_ITER: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_IT) state <= S_FIX;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = (state == S_PREP) && !divIsZero;
    strobe.divZero = (state == S_PREP) && divIsZero;
    strobe.step    = (state == S_ITER);
    strobe.finish  = (state == S_FIX);
  end

  assign busy     = (state != S_IDLE);
  assign ctrlByte = {busy, roundMode, 2'b00, signedMode, 3'b000};
endmodule

// File: rtl/mduDivDatapath.sv
module mduDivDatapath
  import mduDivPkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  strobeT            strobe,
  input  logic              roundMode,
  input  logic              signedMode,
  input  logic [7:0]        ctrlByte,
  output logic [7:0]        rdData,
  output logic              divIsZero
);
  localparam int BYTES = WIDTH / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3 * BYTES);

  logic [WIDTH-1:0] regA, regB, regC;
  logic [WIDTH-1:0] remR, quoR, divR;
  logic negQ, negR;

  logic             negDividend, negDivisor;
  logic [WIDTH:0]   shifted, diff;
  logic             borrow, roundUp;
  logic [WIDTH-1:0] magQ;

  assign negDividend = signedMode & regC[WIDTH-1];
  assign negDivisor  = signedMode & regA[WIDTH-1];
  assign shifted     = {remR, quoR[WIDTH-1]};
  assign diff        = shifted - {1'b0, divR};
  assign borrow      = diff[WIDTH];
  assign roundUp     = roundMode && ({remR, 1'b0} >= {1'b0, divR});
  assign magQ        = quoR + WIDTH'(roundUp);
  assign divIsZero   = (regA == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
      regC <= '0;
      remR <= '0;
      quoR <= '0;
      divR <= '0;
      negQ <= 1'b0;
      negR <= 1'b0;
    end else begin
      if (wrEn && !busy) begin
        for (int i = 0; i < BYTES; i++) begin
          if (addr == ADDR_W'(i))             regA[i*8 +: 8] <= wrData;
          if (addr == ADDR_W'(BYTES + i))     regB[i*8 +: 8] <= wrData;
          if (addr == ADDR_W'(2 * BYTES + i)) regC[i*8 +: 8] <= wrData;
        end
      end
      if (strobe.load) begin
        quoR <= negDividend ? -regC : regC;
        divR <= negDivisor ? -regA : regA;
        remR <= '0;
        negQ <= negDividend ^ negDivisor;
        negR <= negDividend;
      end
      if (strobe.divZero) begin
        regA <= '1;
        regB <= regC;
      end
      if (strobe.step) begin
        remR <= borrow ? shifted[WIDTH-1:0] : diff[WIDTH-1:0];
        quoR <= {quoR[WIDTH-2:0], ~borrow};
      end
      if (strobe.finish) begin
        regA <= negQ ? -magQ : magQ;
        regB <= negR ? -remR : remR;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (addr == ADDR_W'(i))             rdData = regA[i*8 +: 8];
      if (addr == ADDR_W'(BYTES + i))     rdData = regB[i*8 +: 8];
      if (addr == ADDR_W'(2 * BYTES + i)) rdData = regC[i*8 +: 8];
    end
    if (addr == CTRL_ADDR) rdData = ctrlByte;
  end
endmodule

// File: rtl/mduDivTop.sv
module mduDivTop
  import mduDivPkg::*;
#(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  strobeT strobe;
  logic busy, roundMode, signedMode, divIsZero;
  logic [7:0] ctrlByte;

  mduDivCtrl #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .divIsZero(divIsZero), .strobe(strobe), .busy(busy),
    .roundMode(roundMode), .signedMode(signedMode), .ctrlByte(ctrlByte)
  );

  mduDivDatapath #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .strobe(strobe), .roundMode(roundMode),
    .signedMode(signedMode), .ctrlByte(ctrlByte), .rdData(rdData),
    .divIsZero(divIsZero)
  );
endmodule

// File: rtl/mduDivChk.sv
module mduDivChk #(
  parameter int WIDTH  = 64,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              busy,
  input logic              sLoad,
  input logic              sStep,
  input logic              sFinish,
  input logic              sDivZero
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3 * (WIDTH / 8));
  localparam int CW = $clog2(WIDTH + 3) + 1;

  logic [CW-1:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
    else           runCnt <= '0;
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrEn && addr == CTRL_ADDR && wrData[7]) |=> busy);

  p_run_length_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runCnt == CW'(WIDTH + 2) || runCnt == CW'(1)));

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sLoad, sStep, sFinish, sDivZero}));

  p_zero_short_r6: assert property (@(posedge clk) disable iff (!rstN)
    sDivZero |=> !busy);

  p_busy_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTRL_ADDR) |-> (rdData[7] == busy));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTRL_ADDR) |-> (rdData[5:4] == 2'b00 && rdData[2:0] == 3'b000));

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !busy);
endmodule

bind mduDivTop mduDivChk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .busy(busy), .sLoad(strobe.load), .sStep(strobe.step),
  .sFinish(strobe.finish), .sDivZero(strobe.divZero)
);

// File: tb/sim_mduDivTop.sv
module sim_mduDivTop;
  localparam int W  = 64;
  localparam int AW = 5;
  localparam int AB = 0, BB = 8, CB = 16, CA = 24;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [63:0] c, a, q, r;
  } vecT;

  localparam int NV = 13;
  localparam vecT VECS [NV] = '{
    '{8'h80, 64'd100, 64'd7, 64'd14, 64'd2},
    '{8'h80, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16, 64'h0FFF_FFFF_FFFF_FFFF, 64'd15},
    '{8'hC0, 64'd100, 64'd8, 64'd13, 64'd4},
    '{8'hC0, 64'd100, 64'd7, 64'd14, 64'd2},
    '{8'h88, -64'sd7, 64'd2, -64'sd3, -64'sd1},
    '{8'h88, 64'd7, -64'sd2, -64'sd3, 64'd1},
    '{8'hC8, -64'sd7, 64'd2, -64'sd4, -64'sd1},
    '{8'hC8, -64'sd10, -64'sd3, 64'd3, -64'sd1},
    '{8'hC8, 64'd11, -64'sd3, -64'sd4, 64'd2},
    '{8'h88, 64'h8000_0000_0000_0000, -64'sd1, 64'h8000_0000_0000_0000, 64'd0},
    '{8'h80, 64'h8000_0000_0000_0000, -64'sd1, 64'd0, 64'h8000_0000_0000_0000},
    '{8'h80, 64'd5, 64'd5, 64'd1, 64'd0},
    '{8'hC0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'h8000_0000_0000_0000, 64'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  int nCmp = 0, nBad = 0;

  always #4 clk = ~clk;

  mduDivTop #(.WIDTH(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = AW'(a);
    #1;
    d = rdData;
  endtask

  task automatic wr64(input int base, input logic [63:0] v);
    for (int i = 0; i < 8; i++) wr(base + i, v[i*8 +: 8]);
  endtask

  task automatic rd64(input int base, output logic [63:0] v);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      rd(base + i, b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic waitIdle(output int cyc);
    logic [7:0] b;
    cyc = 0;
    rd(CA, b);
    while (b[7] && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      rd(CA, b);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL R2 watchdog: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [7:0] b;
    int cyc;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    rd64(AB, v); check("R10 A after reset", v, 64'd0);
    rd64(BB, v); check("R10 B after reset", v, 64'd0);
    rd64(CB, v); check("R10 C after reset", v, 64'd0);
    rd(CA, b);   check("R10 ctrl after reset", {56'd0, b}, 64'd0);

    // R1: byte lanes and order
    wr64(BB, 64'h0807_0605_0403_0201);
    rd(BB, b);     check("R1 B byte0", {56'd0, b}, 64'h01);
    rd(BB + 7, b); check("R1 B byte7", {56'd0, b}, 64'h08);
    rd64(BB, v);   check("R1 B word", v, 64'h0807_0605_0403_0201);

    // Table of divisions: R2 R3 R4 R5 R9
    for (int k = 0; k < NV; k++) begin
      wr64(CB, VECS[k].c);
      wr64(AB, VECS[k].a);
      wr(CA, VECS[k].ctrl);
      waitIdle(cyc);
      check($sformatf("R2 busy length vec%0d", k), 64'(cyc), 64'(W + 2));
      rd64(AB, v);
      check($sformatf("%s quotient vec%0d",
            VECS[k].ctrl[6] ? "R5" : (VECS[k].ctrl[3] ? "R4" : "R3"), k), v, VECS[k].q);
      rd64(BB, v);
      check($sformatf("%s remainder vec%0d",
            VECS[k].ctrl[3] ? "R4" : "R3", k), v, VECS[k].r);
      rd64(CB, v);
      check($sformatf("R9 dividend kept vec%0d", k), v, VECS[k].c);
    end

    // R6: zero divisor
    wr64(CB, 64'd123);
    wr64(AB, 64'd0);
    wr(CA, 8'h88);
    waitIdle(cyc);
    check("R6 zero divisor busy length", 64'(cyc), 64'd1);
    rd64(AB, v); check("R6 zero divisor quotient", v, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(BB, v); check("R6 zero divisor remainder", v, 64'd123);

    // R7: writes during a run are ignored
    wr64(CB, 64'd100);
    wr64(AB, 64'd7);
    wr(CA, 8'h80);
    repeat (3) @(negedge clk);
    wr(AB, 8'h55);
    wr(CB, 8'h11);
    wr(BB, 8'h22);
    wr(CA, 8'h48);
    rd(CA, b); check("R7 still busy after writes", {56'd0, b}, 64'h80);
    waitIdle(cyc);
    rd64(AB, v); check("R7 quotient unaffected", v, 64'd14);
    rd64(BB, v); check("R7 remainder unaffected", v, 64'd2);
    rd64(CB, v); check("R7 dividend unaffected", v, 64'd100);
    rd(CA, b);   check("R7 modes unaffected", {56'd0, b}, 64'h00);

    // R8: mode readback, reserved bits, no start without bit 7
    wr(CA, 8'h7F);
    rd(CA, b); check("R8 readback of 0x7F", {56'd0, b}, 64'h48);
    @(negedge clk);
    rd(CA, b); check("R8 no start without bit 7", {56'd0, b}, 64'h48);
    wr(CA, 8'h00);
    rd(CA, b); check("R8 readback of 0x00", {56'd0, b}, 64'h00);

    summary();
    $finish;
  end
endmodule